// File: doc/BRIEF.md
# PCM Receive Serial Port

This block collects one 8-bit companded sample per frame from a serial data line. A bit clock and a frame sync set the timing of the capture. A mode input picks which bit clock drives the capture: the dedicated receive bit clock, or the transmit bit clock when both directions share timing. The whole block runs on a fast system clock. The bit clock and the frame sync pass through two-flop synchronizers, and an edge detector turns them into single-cycle events. The serial data line is sampled in the system cycle in which a bit-clock falling edge is detected.

The width of the frame sync pulse, counted in bit-clock falling edges, sets the frame timing:
- A pulse that is high at one falling edge is a short sync. That edge only marks the frame, and the next eight falling edges carry the data.
- A pulse that is high at three or more falling edges is a long sync. The data starts at the first falling edge after the rising edge of the sync.
- A pulse that is exactly two periods wide uses long timing and marks the least significant bit as lost to signalling. The decoder then reads that bit as one half.

The assembled code is presented on a parallel output with a one-cycle valid pulse. A new sync that arrives before a frame is complete drops the partial frame, restarts the capture, and sets a sticky error flag.

Top module: `pcm_rx_port`

## Requirements
- R1: After reset, code_out is 0, code_valid, half_lsb and frame_err are low, and long_frame is 0, which means short sync timing.
- R2: When the frame sync is high at exactly one bit-clock falling edge, the next eight falling edges supply the code, most significant bit first. The completed frame reports long_frame = 0.
- R3: When the frame sync is high at three or more consecutive falling edges, the first falling edge after its rising edge and the seven that follow supply the code, most significant bit first. The frame reports long_frame = 1.
- R4: When the frame sync is high at exactly two falling edges, the code uses R3 timing, code_out bit 0 is forced to 0, and half_lsb is 1. The next frame of any other width returns half_lsb to 0.
- R5: When sync_mode is 1, tx_bclk times the capture and rx_bclk has no effect. When sync_mode is 0, the roles are reversed.
- R6: code_valid is high for exactly one system cycle per completed frame. code_out, half_lsb and long_frame change only in that cycle.
- R7: A rising edge of the frame sync during an incomplete frame discards the captured bits, sets frame_err, and restarts the capture. The next frame is delivered normally.
- R8: frame_err stays set until err_clr is high for a system cycle. If an error is raised in the same cycle as a clear, the flag stays set.
- R9: A frame sync that stays high after a frame completes does not start another frame. A new frame needs a new rising edge of the sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1: capture on tx_bclk; 0: capture on rx_bclk |
| rx_bclk | input | 1 | Receive bit clock |
| tx_bclk | input | 1 | Transmit bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_data | input | 1 | Serial PCM data |
| err_clr | input | 1 | Clears frame_err when high |
| code_out | output | 8 | Last assembled code |
| code_valid | output | 1 | One-cycle pulse when code_out is updated |
| half_lsb | output | 1 | The last code's LSB was lost to signalling and reads as one half |
| long_frame | output | 1 | Sync timing of the last frame (1 = long) |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The assertions check the following on every cycle:
- code_valid is a single-cycle pulse, and code_out holds between pulses.
- Every valid pulse follows a detected bit-clock falling edge.
- A half-LSB code always has bit 0 clear and long timing.
- The error flag does not decay without a clear.

The bench scenarios are the only way to show the rest:
- Bit alignment of each sync width.
- Swapping the bit clock with sync_mode, with the unused clock running in antiphase.
- Discarding a partial frame on a restart.
- Ignoring a sync that is held high past the end of a frame.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    localparam int CODE_W = 8;
    localparam int IDX_W  = $clog2(CODE_W + 1);

    // Framing state: width counts sync-high falling edges, saturating at 3
    typedef struct packed {
        logic             busy;
        logic             armed;
        logic [IDX_W-1:0] idx;
        logic [1:0]       width;
        logic             err;
    } frm_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] sr;
        logic [CODE_W-1:0] code;
        logic              valid;
        logic              half;
        logic              lng;
    } cap_state_t;

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            // STAGES synchronizer flops plus one history flop for edge detection
            logic [STAGES:0] sh_d, sh_q;

            always_comb begin
                sh_d = {sh_q[STAGES-1:0], din[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end

            assign lvl[g]  = sh_q[STAGES-1];
            assign rise[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
            assign fall[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
        end
    endgenerate

endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer
    import pcm_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_fall,
    input  logic fs_lvl,
    input  logic fs_rise,
    input  logic err_clr,
    output logic shift_en,
    output logic done,
    output logic half_o,
    output logic long_o,
    output logic err_o
);

    frm_state_t q, d;
    logic [1:0] w_now;
    logic       start;
    logic       set_err;

    always_comb begin
        d        = q;
        shift_en = 1'b0;
        done     = 1'b0;
        start    = 1'b0;
        set_err  = 1'b0;
        w_now    = q.width;

        if (bit_fall) begin
            if (q.busy) begin
                shift_en = 1'b1;
                // widen only while the sync has been high at every edge so far
                if (fs_lvl && ({{(IDX_W-2){1'b0}}, q.width} == q.idx) && (q.width != 2'd3))
                    w_now = q.width + 2'd1;
                d.width = w_now;
                d.idx   = q.idx + 1'b1;
                if (((w_now >= 2'd2) && (q.idx == IDX_W'(CODE_W - 1))) ||
                    (q.idx == IDX_W'(CODE_W))) begin
                    done   = 1'b1;
                    d.busy = 1'b0;
                end
            end else if (q.armed && fs_lvl) begin
                start    = 1'b1;
                shift_en = 1'b1;
                d.busy   = 1'b1;
                d.armed  = 1'b0;
                d.idx    = IDX_W'(1);
                d.width  = 2'd1;
            end
        end

        if (fs_rise) begin
            if (q.busy && !done) begin
                set_err = 1'b1;
                d.busy  = 1'b0;
            end
            if (!start) d.armed = 1'b1;
        end

        d.err = set_err | (q.err & ~err_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign half_o = (w_now == 2'd2);
    assign long_o = (w_now >= 2'd2);
    assign err_o  = q.err;

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
    import pcm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              done,
    input  logic              half_i,
    input  logic              long_i,
    input  logic              dr,
    output logic [CODE_W-1:0] code,
    output logic              valid,
    output logic              half,
    output logic              lng
);

    cap_state_t        q, d;
    logic [CODE_W-1:0] nsr;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        nsr     = {q.sr[CODE_W-2:0], dr};
        if (shift_en) d.sr = nsr;
        if (done) begin
            d.code  = half_i ? {nsr[CODE_W-1:1], 1'b0} : nsr;
            d.valid = 1'b1;
            d.half  = half_i;
            d.lng   = long_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign code  = q.code;
    assign valid = q.valid;
    assign half  = q.half;
    assign lng   = q.lng;

endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port
    import pcm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              rx_bclk,
    input  logic              tx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_data,
    input  logic              err_clr,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              half_lsb,
    output logic              long_frame,
    output logic              frame_err
);

    logic       bclk_sel;
    logic [1:0] s_lvl, s_rise, s_fall;
    logic       bclk_fall;
    logic       fs_lvl, fs_rise;
    logic       shift_en, done, half_w, long_w;

    assign bclk_sel = sync_mode ? tx_bclk : rx_bclk;

    pcm_rx_sync #(.W(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({rx_fsync, bclk_sel}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    assign bclk_fall = s_fall[0];
    assign fs_lvl    = s_lvl[1];
    assign fs_rise   = s_rise[1];

    pcm_rx_framer u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_fall(bclk_fall),
        .fs_lvl  (fs_lvl),
        .fs_rise (fs_rise),
        .err_clr (err_clr),
        .shift_en(shift_en),
        .done    (done),
        .half_o  (half_w),
        .long_o  (long_w),
        .err_o   (frame_err)
    );

    pcm_rx_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .done    (done),
        .half_i  (half_w),
        .long_i  (long_w),
        .dr      (rx_data),
        .code    (code_out),
        .valid   (code_valid),
        .half    (half_lsb),
        .lng     (long_frame)
    );

endmodule

// File: rtl/pcm_rx_chk.sv
module pcm_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] code_out,
    input logic       code_valid,
    input logic       half_lsb,
    input logic       long_frame,
    input logic       frame_err,
    input logic       err_clr,
    input logic       bit_fall
);

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid);

    assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> ($stable(code_out) && $stable(half_lsb) && $stable(long_frame)));

    assert_valid_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(bit_fall));

    assert_half_zero_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        half_lsb |-> (!code_out[0] && long_frame));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !err_clr) |=> frame_err);

endmodule

bind pcm_rx_port pcm_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_out  (code_out),
    .code_valid(code_valid),
    .half_lsb  (half_lsb),
    .long_frame(long_frame),
    .frame_err (frame_err),
    .err_clr   (err_clr),
    .bit_fall  (bclk_fall)
);

// File: tb/sim_pcm_rx_port.sv
module sim_pcm_rx_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic       rx_bclk = 1'b0;
    logic       tx_bclk = 1'b0;
    logic       rx_fsync = 1'b0;
    logic       rx_data = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] code_out;
    logic       code_valid, half_lsb, long_frame, frame_err;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pcm_rx_port u0 (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
        .rx_bclk(rx_bclk), .tx_bclk(tx_bclk), .rx_fsync(rx_fsync),
        .rx_data(rx_data), .err_clr(err_clr),
        .code_out(code_out), .code_valid(code_valid), .half_lsb(half_lsb),
        .long_frame(long_frame), .frame_err(frame_err)
    );

    // output monitor
    int         vcount = 0;
    int         pulse_bad = 0;
    int         hold_bad = 0;
    logic       prev_valid = 1'b0;
    logic [7:0] prev_code = 8'h00;
    logic [7:0] last_code = 8'h00;
    logic       last_half = 1'b0;
    logic       last_long = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (code_valid) begin
                vcount    <= vcount + 1;
                last_code <= code_out;
                last_half <= half_lsb;
                last_long <= long_frame;
                if (prev_valid) pulse_bad <= pulse_bad + 1;
            end else if (code_out != prev_code) begin
                hold_bad <= hold_bad + 1;
            end
            prev_valid <= code_valid;
            prev_code  <= code_out;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit period: rising half then falling half; the other clock runs in antiphase
    task automatic bit_period(input bit smode, input bit fs, input bit d);
        @(negedge clk);
        if (smode) begin tx_bclk = 1'b1; rx_bclk = 1'b0; end
        else       begin rx_bclk = 1'b1; tx_bclk = 1'b0; end
        rx_fsync = fs;
        rx_data  = d;
        repeat (8) @(negedge clk);
        if (smode) begin tx_bclk = 1'b0; rx_bclk = 1'b1; end
        else       begin rx_bclk = 1'b0; tx_bclk = 1'b1; end
        repeat (7) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] code, input int width, input bit smode);
        int nper;
        nper = ((width > 9) ? width : 9) + 3;
        sync_mode = smode;
        for (int p = 0; p < nper; p++) begin
            logic d;
            if (width >= 2) d = (p < 8) ? code[7-p] : 1'b0;
            else            d = (p >= 1 && p <= 8) ? code[8-p] : 1'b1;
            bit_period(smode, (p < width), d);
        end
        @(negedge clk);
        rx_bclk = 1'b0;
        tx_bclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0] code;
        logic [3:0] width;
        logic       smode;
        logic [7:0] exp_code;
        logic       exp_half;
        logic       exp_long;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 4'd1,  1'b0, 8'hA5, 1'b0, 1'b0},
        '{8'h3C, 4'd3,  1'b0, 8'h3C, 1'b0, 1'b1},
        '{8'h81, 4'd2,  1'b0, 8'h80, 1'b1, 1'b1},
        '{8'hC3, 4'd1,  1'b1, 8'hC3, 1'b0, 1'b0},
        '{8'h7E, 4'd4,  1'b1, 8'h7E, 1'b0, 1'b1},
        '{8'hFF, 4'd2,  1'b1, 8'hFE, 1'b1, 1'b1},
        '{8'h00, 4'd1,  1'b0, 8'h00, 1'b0, 1'b0},
        '{8'h5A, 4'd12, 1'b0, 8'h5A, 1'b0, 1'b1}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk(code_out == 8'h00, "R1 code_out", 32'(code_out), 32'h0);
        chk(!code_valid, "R1 code_valid", 32'(code_valid), 32'h0);
        chk(!half_lsb, "R1 half_lsb", 32'(half_lsb), 32'h0);
        chk(!long_frame, "R1 long_frame short", 32'(long_frame), 32'h0);
        chk(!frame_err, "R1 frame_err", 32'(frame_err), 32'h0);

        // table walk: R2 short, R3 long, R4 two-period, R5 clock select, R9 held sync
        for (int i = 0; i < NV; i++) begin
            string tag;
            vec_t  v;
            v = VECS[i];
            if (v.smode)           tag = "R5";
            else if (v.width == 1) tag = "R2";
            else if (v.width == 2) tag = "R4";
            else if (v.width > 9)  tag = "R9";
            else                   tag = "R3";
            base = vcount;
            run_frame(v.code, int'(v.width), v.smode);
            chk(vcount == base + 1, {tag, " one frame"}, 32'(vcount - base), 32'd1);
            chk(last_code == v.exp_code, {tag, " code"}, 32'(last_code), 32'(v.exp_code));
            chk(last_half == v.exp_half, {tag, " half_lsb"}, 32'(last_half), 32'(v.exp_half));
            chk(last_long == v.exp_long, {tag, " long_frame"}, 32'(last_long), 32'(v.exp_long));
        end
        chk(!frame_err, "R7 no error on clean frames", 32'(frame_err), 32'h0);

        // R7 restart: partial long frame, then a new frame begins
        base = vcount;
        sync_mode = 1'b0;
        for (int p = 0; p < 5; p++) bit_period(1'b0, (p < 3), 1'b1);
        run_frame(8'h96, 3, 1'b0);
        chk(vcount == base + 1, "R7 only restarted frame delivered", 32'(vcount - base), 32'd1);
        chk(last_code == 8'h96, "R7 restarted code", 32'(last_code), 32'h96);
        chk(frame_err, "R7 frame_err set", 32'(frame_err), 32'h1);

        // R8 sticky, then clear
        repeat (40) @(negedge clk);
        chk(frame_err, "R8 frame_err held", 32'(frame_err), 32'h1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
        chk(!frame_err, "R8 frame_err cleared", 32'(frame_err), 32'h0);

        // R4 half flag returns low on a normal frame
        run_frame(8'h81, 2, 1'b0);
        chk(half_lsb, "R4 half_lsb set", 32'(half_lsb), 32'h1);
        run_frame(8'h81, 1, 1'b0);
        chk(!half_lsb && code_out == 8'h81, "R4 half_lsb cleared",
            {23'd0, half_lsb, code_out}, 32'h081);

        // R6 pulse width and hold
        chk(pulse_bad == 0, "R6 valid single cycle", 32'(pulse_bad), 32'h0);
        chk(hold_bad == 0, "R6 code held between frames", 32'(hold_bad), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule